// File: doc/BRIEF.md
# Virtual Scan Hub Controller

This block sits behind a standard JTAG test access port and shares the two user data-register scan paths among several virtual scan nodes. It follows the TAP state machine on its own by decoding TMS on every rising TCK edge. It keeps a private 10-bit instruction register. One instruction code turns data-register scans into virtual instruction scans. A virtual instruction word carries a node address above a VIR value field. A second code turns data-register scans into virtual data scans. These are steered to the node that was last addressed.

For each node the hub drives one-hot virtual state strobes and an enable. It also chooses which serial stream reaches TDO. The shifted bits themselves stay in the nodes: each node watches its strobes and returns one serial bit on `node_tdo`. Address 0 names the hub itself, so no node is enabled. An address above the node count also enables no node. In both cases virtual data scans pass through a one-bit bypass stage, so the chain never breaks.

Top module: `vjtag_hub`

## Requirements
- R1: The hub tracks the standard 16-state TAP sequence from TMS sampled on rising TCK. Five consecutive rising edges with TMS high always leave it in Test-Logic-Reset, from any state.
- R2: The instruction register is 10 bits wide and shifts TDI in at its MSB. Capture-IR loads 0b0000000001, which leaves LSB first on TDO. The shifted value takes effect at Update-IR. Test-Logic-Reset sets it to all ones.
- R3: With instruction 0x00E, a DR scan is ADDR_W+VIR_W bits long (ADDR_W = clog2(NODES+1)), with the VIR value in the low VIR_W bits and the address above it. Capture loads the current {address, VIR} so that it shifts out LSB first. Update-DR latches both, and `vir_out` shows the VIR value from the next cycle on.
- R4: With instruction 0x00C, the Capture, Shift, Exit1, Pause, Exit2 and Update DR states each raise their own strobe (`node_cdr` … `node_udr`), only for the addressed node and only in that state.
- R5: With instruction 0x00E, Capture-DR raises `node_cir` for the node currently addressed. Update-DR raises `node_uir` for the node named by the incoming address field.
- R6: In Shift-DR under 0x00C with a valid node address k (1..NODES), TDO carries `node_tdo[k-1]`.
- R7: In Shift-DR under any code other than 0x00E/0x00C, or under 0x00C with address 0 or above NODES, TDO comes from a one-bit bypass stage. That stage is cleared at Capture-DR, so TDO shows 0 first and then TDI delayed by one bit.
- R8: TDO changes only on the falling edge of TCK.
- R9: An active-low asynchronous clear puts the hub in Test-Logic-Reset, sets the instruction to all ones and clears the address and VIR.
- R10: Whenever the hub is in Test-Logic-Reset, the latched address and VIR are cleared, so `node_en` and `vir_out` read zero afterwards.
- R11: `node_en[k-1]` is high exactly when the latched address equals k, for k from 1 to NODES. Address 0 and out-of-range addresses enable nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Device-wide asynchronous clear, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| node_tdo | input | NODES | Serial output of each node's data chain |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| vir_out | output | VIR_W | Latched virtual instruction value |
| node_en | output | NODES | One-hot enable of the addressed node |
| node_cdr | output | NODES | Virtual Capture-DR strobe per node |
| node_sdr | output | NODES | Virtual Shift-DR strobe per node |
| node_e1dr | output | NODES | Virtual Exit1-DR strobe per node |
| node_pdr | output | NODES | Virtual Pause-DR strobe per node |
| node_e2dr | output | NODES | Virtual Exit2-DR strobe per node |
| node_udr | output | NODES | Virtual Update-DR strobe per node |
| node_cir | output | NODES | Virtual Capture-IR strobe per node |
| node_uir | output | NODES | Virtual Update-IR strobe per node |

## Verification
Several instruction scans run first: the virtual instruction code, the virtual data code, and an unrelated code. These separate the three TDO sources. The Capture-IR pattern seen on TDO shows that the IR shifts in the right direction. Virtual instruction writes go to the first node, the last node, address 0 and an out-of-range address. This separates true per-node routing from a decoder that ignores the address. The read-back of the previous word proves the bit order of the address and VIR fields. Data scans with a pause in the middle exercise all six virtual DR strobes. Finally, a TMS-high escape from inside a scan and an asynchronous clear in mid-scan show that the selection is dropped in both cases.

// File: rtl/vjh_pkg.sv
package vjh_pkg;
    localparam int IR_W = 10;
    localparam logic [IR_W-1:0] CODE_VINSTR = 10'h00E;
    localparam logic [IR_W-1:0] CODE_VDATA  = 10'h00C;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_t;
endpackage

// File: rtl/vjh_tap_tracker.sv
module vjh_tap_tracker
    import vjh_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state
);
    typedef struct packed { tap_state_t st; } trk_t;
    trk_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            TS_RESET:  r_d.st = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   r_d.st = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: r_d.st = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: r_d.st = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: r_d.st = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: r_d.st = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: r_d.st = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: r_d.st = tms ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: r_d.st = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: r_d.st = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: r_d.st = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: r_d.st = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: r_d.st = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: r_d.st = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: r_d.st = tms ? TS_UPD_IR : TS_SHF_IR;
            TS_UPD_IR: r_d.st = tms ? TS_SEL_DR : TS_IDLE;
            default:   r_d.st = TS_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: TS_RESET};
        else        r_q <= r_d;
    end

    assign state = r_q.st;
endmodule

// File: rtl/vjh_ir_reg.sv
module vjh_ir_reg
    import vjh_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_t      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_code,
    output logic            ir_lsb
);
    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] code;
    } ir_t;
    ir_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (state)
            TS_RESET:  r_d.code = '1;
            TS_CAP_IR: r_d.sh   = IR_W'(1);
            TS_SHF_IR: r_d.sh   = {tdi, r_q.sh[IR_W-1:1]};
            TS_UPD_IR: r_d.code = r_q.sh;
            default:   ;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) r_q <= '{sh: '0, code: '1};
        else        r_q <= r_d;
    end

    assign ir_code = r_q.code;
    assign ir_lsb  = r_q.sh[0];
endmodule

// File: rtl/vjh_vir_reg.sv
module vjh_vir_reg
    import vjh_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int VIR_W  = 4
) (
    input  logic              tck,
    input  logic              rst_n,
    input  tap_state_t        state,
    input  logic              sel,
    input  logic              tdi,
    output logic [ADDR_W-1:0] addr,
    output logic [VIR_W-1:0]  vir,
    output logic [ADDR_W-1:0] next_addr,
    output logic              sh_lsb
);
    localparam int WORD_W = ADDR_W + VIR_W;

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [ADDR_W-1:0] addr;
        logic [VIR_W-1:0]  vir;
    } vr_t;
    vr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (state == TS_RESET) begin
            r_d.addr = '0;
            r_d.vir  = '0;
        end else if (sel) begin
            unique case (state)
                TS_CAP_DR: r_d.sh = {r_q.addr, r_q.vir};
                TS_SHF_DR: r_d.sh = {tdi, r_q.sh[WORD_W-1:1]};
                TS_UPD_DR: begin
                    r_d.addr = r_q.sh[WORD_W-1:VIR_W];
                    r_d.vir  = r_q.sh[VIR_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign addr      = r_q.addr;
    assign vir       = r_q.vir;
    assign next_addr = r_q.sh[WORD_W-1:VIR_W];
    assign sh_lsb    = r_q.sh[0];
endmodule

// File: rtl/vjtag_hub.sv
module vjtag_hub
    import vjh_pkg::*;
#(
    parameter int NODES = 4,
    parameter int VIR_W = 4
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [NODES-1:0] node_tdo,
    output logic             tdo,
    output logic [VIR_W-1:0] vir_out,
    output logic [NODES-1:0] node_en,
    output logic [NODES-1:0] node_cdr,
    output logic [NODES-1:0] node_sdr,
    output logic [NODES-1:0] node_e1dr,
    output logic [NODES-1:0] node_pdr,
    output logic [NODES-1:0] node_e2dr,
    output logic [NODES-1:0] node_udr,
    output logic [NODES-1:0] node_cir,
    output logic [NODES-1:0] node_uir
);
    localparam int ADDR_W = $clog2(NODES + 1);

    tap_state_t        tap_state;
    logic [IR_W-1:0]   ir_code;
    logic              ir_lsb;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] new_addr;
    logic              vir_lsb;
    logic              is_vinstr;
    logic              is_vdata;
    logic [NODES-1:0]  new_hit;
    logic              node_bit;
    logic              node_ok;
    logic              byp_d, byp_q;
    logic              tdo_d, tdo_q;

    assign is_vinstr = (ir_code == CODE_VINSTR);
    assign is_vdata  = (ir_code == CODE_VDATA);

    vjh_tap_tracker u_tap (
        .tck(tck), .rst_n(rst_n), .tms(tms), .state(tap_state)
    );

    vjh_ir_reg u_ir (
        .tck(tck), .rst_n(rst_n), .state(tap_state), .tdi(tdi),
        .ir_code(ir_code), .ir_lsb(ir_lsb)
    );

    vjh_vir_reg #(.ADDR_W(ADDR_W), .VIR_W(VIR_W)) u_vir (
        .tck(tck), .rst_n(rst_n), .state(tap_state), .sel(is_vinstr), .tdi(tdi),
        .addr(cur_addr), .vir(vir_out), .next_addr(new_addr), .sh_lsb(vir_lsb)
    );

    for (genvar g = 0; g < NODES; g++) begin : g_node
        assign node_en[g]   = (cur_addr == ADDR_W'(g + 1));
        assign new_hit[g]   = (new_addr == ADDR_W'(g + 1));
        assign node_cdr[g]  = node_en[g] && is_vdata && (tap_state == TS_CAP_DR);
        assign node_sdr[g]  = node_en[g] && is_vdata && (tap_state == TS_SHF_DR);
        assign node_e1dr[g] = node_en[g] && is_vdata && (tap_state == TS_EX1_DR);
        assign node_pdr[g]  = node_en[g] && is_vdata && (tap_state == TS_PAU_DR);
        assign node_e2dr[g] = node_en[g] && is_vdata && (tap_state == TS_EX2_DR);
        assign node_udr[g]  = node_en[g] && is_vdata && (tap_state == TS_UPD_DR);
        assign node_cir[g]  = node_en[g] && is_vinstr && (tap_state == TS_CAP_DR);
        assign node_uir[g]  = new_hit[g] && is_vinstr && (tap_state == TS_UPD_DR);
    end

    assign node_bit = |(node_tdo & node_en);
    assign node_ok  = |node_en;

    always_comb begin
        byp_d = byp_q;
        if (tap_state == TS_CAP_DR)      byp_d = 1'b0;
        else if (tap_state == TS_SHF_DR) byp_d = tdi;

        tdo_d = byp_q;
        if (tap_state == TS_SHF_IR)                             tdo_d = ir_lsb;
        else if (tap_state == TS_SHF_DR && is_vinstr)           tdo_d = vir_lsb;
        else if (tap_state == TS_SHF_DR && is_vdata && node_ok) tdo_d = node_bit;
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) byp_q <= 1'b0;
        else        byp_q <= byp_d;
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) tdo_q <= 1'b0;
        else        tdo_q <= tdo_d;
    end

    assign tdo = tdo_q;
endmodule

// File: rtl/vjh_hub_check.sv
module vjh_hub_check
    import vjh_pkg::*;
#(
    parameter int NODES = 4,
    parameter int VIR_W = 4
) (
    input logic             tck,
    input logic             rst_n,
    input logic             tms,
    input tap_state_t       state,
    input logic [IR_W-1:0]  ir_code,
    input logic [VIR_W-1:0] vir_out,
    input logic [NODES-1:0] node_en,
    input logic [NODES-1:0] node_sdr,
    input logic [NODES-1:0] node_uir,
    input logic             byp
);
    logic [2:0] high_run;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)               high_run <= '0;
        else if (!tms)            high_run <= '0;
        else if (high_run != 3'd7) high_run <= high_run + 3'd1;
    end

    p_tlr_after_five_r1: assert property (@(posedge tck) disable iff (!rst_n)
        (high_run >= 3'd5) |-> (state == TS_RESET));

    p_ir_hold_r2: assert property (@(posedge tck) disable iff (!rst_n)
        (state != TS_UPD_IR && state != TS_RESET) |=> $stable(ir_code));

    p_vir_hold_r3: assert property (@(posedge tck) disable iff (!rst_n)
        (state != TS_RESET && !(state == TS_UPD_DR && ir_code == CODE_VINSTR))
        |=> $stable(vir_out));

    p_sdr_single_r4: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0(node_sdr));

    p_uir_single_r5: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0(node_uir));

    p_bypass_clear_r7: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TS_CAP_DR) |=> (byp == 1'b0));

    p_clear_r9: assert property (@(posedge tck)
        !rst_n |=> (state == TS_RESET));

    p_en_single_r11: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0(node_en));
endmodule

bind vjtag_hub vjh_hub_check #(.NODES(NODES), .VIR_W(VIR_W)) u_hub_check (
    .tck(tck), .rst_n(rst_n), .tms(tms), .state(tap_state), .ir_code(ir_code),
    .vir_out(vir_out), .node_en(node_en), .node_sdr(node_sdr),
    .node_uir(node_uir), .byp(byp_q)
);

// File: tb/tb_vjtag_hub.sv
`timescale 1ns/1ps
module tb_vjtag_hub;
    localparam int NODES = 4;
    localparam int VIR_W = 4;
    localparam int AW    = 3;
    localparam int LW    = AW + VIR_W;

    // behavioural state numbering (bench only)
    localparam int RST = 0, IDL = 1, SDR = 2, CDR = 3, SHD = 4, E1D = 5, PSD = 6, E2D = 7, UDR = 8;
    localparam int SIR = 9, CIR = 10, SHI = 11, E1I = 12, PSI = 13, E2I = 14, UIR = 15;

    logic tck = 0, rst_n = 0, tms = 1, tdi = 0;
    logic [NODES-1:0] node_tdo = '0;
    logic tdo;
    logic [VIR_W-1:0] vir_out;
    logic [NODES-1:0] node_en, node_cdr, node_sdr, node_e1dr, node_pdr, node_e2dr, node_udr, node_cir, node_uir;

    vjtag_hub #(.NODES(NODES), .VIR_W(VIR_W)) dut (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .node_tdo(node_tdo), .tdo(tdo),
        .vir_out(vir_out), .node_en(node_en), .node_cdr(node_cdr), .node_sdr(node_sdr),
        .node_e1dr(node_e1dr), .node_pdr(node_pdr), .node_e2dr(node_e2dr), .node_udr(node_udr),
        .node_cir(node_cir), .node_uir(node_uir)
    );

    always #5 tck = ~tck;

    int vectors = 0, fails = 0;
    bit done = 0;
    int lfsr = 32'h1ACE5;

    // reference model
    int m_st = RST;
    logic [9:0] m_ir = '1, m_irsh = '0;
    logic [LW-1:0] m_vsh = '0;
    int m_addr = 0;
    logic [VIR_W-1:0] m_vir = '0;
    logic m_byp = 0;
    logic tdo_seen;

    task automatic model_clear();
        m_st = RST; m_ir = '1; m_irsh = '0; m_vsh = '0; m_addr = 0; m_vir = '0; m_byp = 0;
    endtask

    function automatic int nxt(int s, logic t);
        case (s)
            RST: return t ? RST : IDL;
            IDL: return t ? SDR : IDL;
            SDR: return t ? SIR : CDR;
            CDR, SHD: return t ? E1D : SHD;
            E1D: return t ? UDR : PSD;
            PSD: return t ? E2D : PSD;
            E2D: return t ? UDR : SHD;
            UDR, UIR: return t ? SDR : IDL;
            SIR: return t ? RST : CIR;
            CIR, SHI: return t ? E1I : SHI;
            E1I: return t ? UIR : PSI;
            PSI: return t ? E2I : PSI;
            E2I: return t ? UIR : SHI;
            default: return RST;
        endcase
    endfunction

    always @(posedge tck) begin
        if (!rst_n) model_clear();
        else begin
            if (m_st == RST) begin m_ir = '1; m_addr = 0; m_vir = '0; end
            if (m_st == CIR) m_irsh = 10'd1;
            if (m_st == SHI) m_irsh = {tdi, m_irsh[9:1]};
            if (m_st == UIR) m_ir = m_irsh;
            if (m_st == CDR) begin m_byp = 0; if (m_ir == 10'h00E) m_vsh = {m_addr[AW-1:0], m_vir}; end
            if (m_st == SHD) begin m_byp = tdi; if (m_ir == 10'h00E) m_vsh = {tdi, m_vsh[LW-1:1]}; end
            if (m_st == UDR && m_ir == 10'h00E) begin m_addr = int'(m_vsh[LW-1:VIR_W]); m_vir = m_vsh[VIR_W-1:0]; end
            m_st = nxt(m_st, tms);
        end
    end

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [NODES-1:0] gate(int s, logic [9:0] code, int a);
        logic [NODES-1:0] v = '0;
        if (m_st == s && m_ir == code && a >= 1 && a <= NODES) v[a-1] = 1'b1;
        return v;
    endfunction

    task automatic compare();
        int na = int'(m_vsh[LW-1:VIR_W]);
        logic [NODES-1:0] en = '0;
        if (m_addr >= 1 && m_addr <= NODES) en[m_addr-1] = 1'b1;
        check("R11", "node_en", 32'(node_en), 32'(en));
        check("R3", "vir_out", 32'(vir_out), 32'(m_vir));
        check("R4", "node_cdr", 32'(node_cdr), 32'(gate(CDR, 10'h00C, m_addr)));
        check("R4", "node_sdr", 32'(node_sdr), 32'(gate(SHD, 10'h00C, m_addr)));
        check("R4", "node_e1dr", 32'(node_e1dr), 32'(gate(E1D, 10'h00C, m_addr)));
        check("R4", "node_pdr", 32'(node_pdr), 32'(gate(PSD, 10'h00C, m_addr)));
        check("R4", "node_e2dr", 32'(node_e2dr), 32'(gate(E2D, 10'h00C, m_addr)));
        check("R4", "node_udr", 32'(node_udr), 32'(gate(UDR, 10'h00C, m_addr)));
        check("R5", "node_cir", 32'(node_cir), 32'(gate(CDR, 10'h00E, m_addr)));
        check("R5", "node_uir", 32'(node_uir), 32'(gate(UDR, 10'h00E, na)));
        if (m_st == SHI) check("R2", "tdo ir", 32'(tdo), 32'(m_irsh[0]));
        else if (m_st == SHD) begin
            if (m_ir == 10'h00E) check("R3", "tdo vir", 32'(tdo), 32'(m_vsh[0]));
            else if (m_ir == 10'h00C && m_addr >= 1 && m_addr <= NODES)
                check("R6", "tdo node", 32'(tdo), 32'(node_tdo[m_addr-1]));
            else check("R7", "tdo bypass", 32'(tdo), 32'(m_byp));
        end
    endtask

    // one TCK cycle: compare after the falling edge, drive, then vary node outputs after the rising edge
    task automatic cyc(logic t, logic d);
        @(negedge tck); #1;
        compare();
        tdo_seen = tdo;
        tms = t; tdi = d;
        @(posedge tck); #1;
        check("R8", "tdo steady over rising edge", 32'(tdo), 32'(tdo_seen));
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
        node_tdo = lfsr[NODES-1:0];
    endtask

    task automatic tms_reset();
        for (int i = 0; i < 5; i++) cyc(1, 0);
        cyc(0, 0);
    endtask

    task automatic load_ir(logic [9:0] code);
        cyc(1, 0); cyc(1, 0); cyc(0, 0); cyc(0, 0);
        for (int i = 0; i < 10; i++) cyc(i == 9, code[i]);
        cyc(1, 0); cyc(0, 0);
    endtask

    task automatic scan_dr(logic [31:0] data, int len, int pause_at);
        cyc(1, 0); cyc(0, 0); cyc(0, 0);
        for (int i = 0; i < len; i++) begin
            cyc(i == len - 1 || i == pause_at, data[i]);
            if (i == pause_at && i != len - 1) begin cyc(0, 0); cyc(0, 0); cyc(1, 0); cyc(0, 0); end
        end
        cyc(1, 0); cyc(0, 0);
    endtask

    task automatic vwrite(int a, logic [VIR_W-1:0] v);
        load_ir(10'h00E);
        scan_dr({25'd0, a[AW-1:0], v}, LW, -1);
    endtask

    initial begin
        repeat (3) @(posedge tck);
        #1;
        check("R9", "node_en in clear", 32'(node_en), 0);
        check("R9", "vir_out in clear", 32'(vir_out), 0);
        rst_n = 1;
        tms_reset();
        // R2: capture pattern visible during IR scan, unrelated code -> bypass (R7)
        load_ir(10'h006);
        scan_dr(32'hA5, 8, 3);
        // R3/R5/R11: address node 1 then node 4, read back previous word
        vwrite(1, 4'h5);
        check("R3", "vir after write", 32'(vir_out), 32'h5);
        check("R11", "node_en node 1", 32'(node_en), 32'h1);
        load_ir(10'h00C);
        scan_dr(32'h3C, 8, 2);                // R4/R6 with pause
        vwrite(4, 4'hA);
        check("R11", "node_en node 4", 32'(node_en), 32'h8);
        load_ir(10'h00C);
        scan_dr(32'h96, 8, 5);
        // address 0 and out-of-range -> bypass (R7, R11)
        vwrite(0, 4'h3);
        load_ir(10'h00C);
        scan_dr(32'hD1, 8, -1);
        vwrite(6, 4'hF);
        check("R11", "node_en out of range", 32'(node_en), 0);
        load_ir(10'h00C);
        scan_dr(32'h4B, 8, 1);
        // R1/R10: TMS escape from inside a scan
        vwrite(2, 4'h9);
        load_ir(10'h00C);
        cyc(1, 0); cyc(0, 0); cyc(0, 0); cyc(0, 1); cyc(0, 0);
        tms_reset();
        check("R1", "node_en after TMS reset", 32'(node_en), 0);
        check("R10", "vir_out after TMS reset", 32'(vir_out), 0);
        scan_dr(32'h77, 8, -1);
        // R9: asynchronous clear in mid-scan
        vwrite(3, 4'h6);
        load_ir(10'h00C);
        cyc(1, 0); cyc(0, 0); cyc(0, 1);
        @(negedge tck); #2;
        rst_n = 0; model_clear();
        #1;
        check("R9", "node_en after clear", 32'(node_en), 0);
        check("R9", "vir_out after clear", 32'(vir_out), 0);
        check("R9", "tdo after clear", 32'(tdo), 0);
        @(posedge tck); #1; rst_n = 1; tms = 1;
        tms_reset();
        vwrite(3, 4'hC);
        load_ir(10'h00C);
        scan_dr(32'hE2, 8, 4);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge tck);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule